// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM

This block is a clocked single-port memory with a pipelined interface that needs no idle cycle when the bus turns around. At every enabled rising edge the controller samples one command. The command can load an external address and start a read or write burst, step the current burst to its next word, deselect the device, or do nothing because the edge is stalled. A small counter supplies the low address bits during a burst and wraps in linear order. Read data leaves through an output register. Write data is taken from the bus two edges after its command, so reads and writes can alternate on the shared data bus at full rate.

The data bus is modelled as three ports: input data, output data and a drive enable. The drive enable combines a registered drive flag with the output-enable and sleep inputs, and both of those act without waiting for a clock. A stall input freezes all internal state and the bus. The sleep input makes the device ignore the clock and release the bus.

Top module: `pbsram`

## Requirements
- R1: After reset, `dq_oe` is 0. A continue command issued before any burst has been started is treated as a deselect continue and never drives the bus.
- R2: A read begin is accepted at an enabled edge n when `sel0_n`=0, `sel1`=1, `sel2_n`=0, `adv_ld`=0 and `wr_n`=1. The word at `addr` is then on `dq_out` between enabled edges n+1 and n+2.
- R3: A write begin is accepted when the device is selected, `adv_ld`=0 and `wr_n`=0. At enabled edge n+2, each byte lane g whose `byte_wr_n[g]`=0 at edge n takes `dq_in` bits [8g+7:8g]. The other lanes keep their contents.
- R4: A continue is a command with `adv_ld`=1, whatever the enables and `wr_n` show. It repeats the type of the burst in progress (read, write or deselect). It adds 1 modulo 4 to the two low address bits and keeps the upper address bits, so a burst loaded at low bits 3 visits 3,0,1,2.
- R5: A write command, begin or continue, with every `byte_wr_n` bit at 1 changes no memory word. The burst counter still steps on a continue of that kind.
- R6: A begin with any chip enable inactive (`sel0_n`=1, `sel1`=0 or `sel2_n`=1) performs no operation and does not drive the bus two edges later. Continues that follow it are deselect continues.
- R7: `dq_oe` is 1 only while a read's data phase is active and `out_en_n`=0. `out_en_n` acts without a clock. A read done with `out_en_n`=1 is a dummy read and leaves the bus undriven.
- R8: During the data phase of a write, `dq_oe` is 0 whatever `out_en_n` shows.
- R9: An edge with `clk_en_n`=1 is ignored. Memory, burst state, `dq_out` and the drive flag all hold, so an active read keeps driving and a write phase stays undriven.
- R10: While `sleep`=1, `dq_oe` is 0 at once, clock edges are ignored and all state holds. Operation resumes when `sleep` returns to 0.
- R11: A read whose command immediately follows a write to the same address returns the newly written lanes merged with the old contents of the unwritten lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of control state |
| sel0_n | input | 1 | Chip enable, active low |
| sel1 | input | 1 | Chip enable, active high |
| sel2_n | input | 1 | Chip enable, active low |
| adv_ld | input | 1 | 1 = continue burst, 0 = load address / begin |
| wr_n | input | 1 | 0 = write begin, 1 = read begin |
| byte_wr_n | input | BYTES | Per-lane write enables, active low |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| clk_en_n | input | 1 | Clock enable, active low; 1 stalls the edge |
| sleep | input | 1 | Power-down: ignore clock, release bus |
| addr | input | ADDR_W | Word address for begin commands |
| dq_in | input | BYTES*LANE_W | Data bus as seen by the device |
| dq_out | output | BYTES*LANE_W | Read data register |
| dq_oe | output | 1 | Bus drive enable |

## Verification
The memory is first filled with whole-word write bursts. The bench then applies directed sequences: bursts whose start address has low bits 3, so the wrap shows in the order of the returned words; a write followed at once by a read of the same address with partial byte masks, which separates the merge of fresh lanes from a read of stale contents; write aborts, which show whether any lane was written; and deselect begins driven through each of the three enables. Stalls and sleep are inserted in the middle of read and write phases to show whether the bus and the pipeline hold or move. A long constrained-random mix of every command type, with random masks, output enables and occasional stalls and sleep, is compared cycle by cycle with a transaction model in the bench. In that model every read sees all writes ordered before it.

// File: rtl/pbsram_pkg.sv
package pbsram_pkg;
   typedef enum logic [1:0] {
      OP_DESEL = 2'd0,
      OP_READ  = 2'd1,
      OP_WRITE = 2'd2
   } op_e;
endpackage

// File: rtl/pbsram_ctrl.sv
// Command decode and burst address counter (first pipeline stage).
module pbsram_ctrl
   import pbsram_pkg::*;
#(
   parameter int ADDR_W  = 6,
   parameter int BYTES   = 2,
   parameter int BURST_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              sel,
   input  logic              adv_ld,
   input  logic              wr_n,
   input  logic [BYTES-1:0]  byte_wr_n,
   input  logic [ADDR_W-1:0] addr,
   output op_e               s1_op,
   output logic [ADDR_W-1:0] s1_addr,
   output logic [BYTES-1:0]  s1_mask
);
   if (BURST_W < 1 || BURST_W > ADDR_W) begin : g_bad_burst
      $error("pbsram_ctrl: BURST_W must lie in 1..ADDR_W");
   end

   logic [BURST_W-1:0] lo_nx;
   logic [ADDR_W-1:0]  step_addr;
   op_e                op_nx;
   logic [ADDR_W-1:0]  addr_nx;
   logic [BYTES-1:0]   mask_nx;

   assign lo_nx = s1_addr[BURST_W-1:0] + BURST_W'(1);

   if (ADDR_W > BURST_W) begin : g_hi
      assign step_addr = {s1_addr[ADDR_W-1:BURST_W], lo_nx};
   end else begin : g_flat
      assign step_addr = lo_nx;
   end

   always_comb begin
      if (!adv_ld) begin
         op_nx   = sel ? (wr_n ? OP_READ : OP_WRITE) : OP_DESEL;
         addr_nx = sel ? addr : s1_addr;
      end else begin
         op_nx   = s1_op;
         addr_nx = step_addr;
      end
      mask_nx = (op_nx == OP_WRITE) ? ~byte_wr_n : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_op   <= OP_DESEL;
         s1_addr <= '0;
         s1_mask <= '0;
      end else if (en) begin
         s1_op   <= op_nx;
         s1_addr <= addr_nx;
         s1_mask <= mask_nx;
      end
   end
endmodule

// File: rtl/pbsram_array.sv
// Storage array, one register bank per byte lane.
module pbsram_array #(
   parameter int ADDR_W = 6,
   parameter int BYTES  = 2,
   parameter int LANE_W = 8
) (
   input  logic                    clk,
   input  logic                    we,
   input  logic [BYTES-1:0]        wmask,
   input  logic [ADDR_W-1:0]       waddr,
   input  logic [BYTES*LANE_W-1:0] wdata,
   input  logic [ADDR_W-1:0]       raddr,
   output logic [BYTES*LANE_W-1:0] rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   if (DEPTH * BYTES * LANE_W > 65536) begin : g_too_big
      $error("pbsram_array: array exceeds the register-array budget");
   end

   for (genvar g = 0; g < BYTES; g++) begin : g_lane
      logic [LANE_W-1:0] bank [DEPTH];

      always_ff @(posedge clk) begin
         if (we && wmask[g]) begin
            bank[waddr] <= wdata[g*LANE_W +: LANE_W];
         end
      end

      assign rdata[g*LANE_W +: LANE_W] = bank[raddr];
   end
endmodule

// File: rtl/pbsram_pipe.sv
// Second stage: late-write issue, read merge, output register, bus drive.
module pbsram_pipe
   import pbsram_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int BYTES  = 2,
   parameter int LANE_W = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    en,
   input  op_e                     s1_op,
   input  logic [ADDR_W-1:0]       s1_addr,
   input  logic [BYTES-1:0]        s1_mask,
   input  logic [BYTES*LANE_W-1:0] dq_in,
   input  logic [BYTES*LANE_W-1:0] rd_data,
   input  logic                    out_en_n,
   input  logic                    sleep,
   output logic                    wr_en,
   output logic [ADDR_W-1:0]       wr_addr,
   output logic [BYTES-1:0]        wr_mask,
   output logic                    s2_write,
   output logic [BYTES*LANE_W-1:0] dq_out,
   output logic                    dq_oe
);
   localparam int DW = BYTES * LANE_W;

   logic [DW-1:0] merged;
   logic          drive_q;

   for (genvar g = 0; g < BYTES; g++) begin : g_merge
      logic hit;
      assign hit = s2_write && wr_mask[g] && (wr_addr == s1_addr);
      assign merged[g*LANE_W +: LANE_W] =
         hit ? dq_in[g*LANE_W +: LANE_W] : rd_data[g*LANE_W +: LANE_W];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s2_write <= 1'b0;
         wr_addr  <= '0;
         wr_mask  <= '0;
         drive_q  <= 1'b0;
         dq_out   <= '0;
      end else if (en) begin
         s2_write <= (s1_op == OP_WRITE);
         wr_addr  <= s1_addr;
         wr_mask  <= s1_mask;
         drive_q  <= (s1_op == OP_READ);
         if (s1_op == OP_READ) begin
            dq_out <= merged;
         end
      end
   end

   assign wr_en = en && s2_write;
   assign dq_oe = drive_q && !out_en_n && !sleep;
endmodule

// File: rtl/pbsram.sv
module pbsram
   import pbsram_pkg::*;
#(
   parameter int ADDR_W  = 6,
   parameter int BYTES   = 2,
   parameter int LANE_W  = 8,
   parameter int BURST_W = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    sel0_n,
   input  logic                    sel1,
   input  logic                    sel2_n,
   input  logic                    adv_ld,
   input  logic                    wr_n,
   input  logic [BYTES-1:0]        byte_wr_n,
   input  logic                    out_en_n,
   input  logic                    clk_en_n,
   input  logic                    sleep,
   input  logic [ADDR_W-1:0]       addr,
   input  logic [BYTES*LANE_W-1:0] dq_in,
   output logic [BYTES*LANE_W-1:0] dq_out,
   output logic                    dq_oe
);
   localparam int DW = BYTES * LANE_W;

   if (BYTES < 1 || LANE_W < 1) begin : g_bad_shape
      $error("pbsram: BYTES and LANE_W must be positive");
   end

   logic              en;
   logic              sel;
   op_e               s1_op;
   logic [ADDR_W-1:0] s1_addr;
   logic [BYTES-1:0]  s1_mask;
   logic              wr_en;
   logic [ADDR_W-1:0] wr_addr;
   logic [BYTES-1:0]  wr_mask;
   logic              s2_write;
   logic [DW-1:0]     rd_data;

   assign en  = !clk_en_n && !sleep;
   assign sel = !sel0_n && sel1 && !sel2_n;

   pbsram_ctrl #(.ADDR_W(ADDR_W), .BYTES(BYTES), .BURST_W(BURST_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .en(en), .sel(sel), .adv_ld(adv_ld),
      .wr_n(wr_n), .byte_wr_n(byte_wr_n), .addr(addr),
      .s1_op(s1_op), .s1_addr(s1_addr), .s1_mask(s1_mask)
   );

   pbsram_array #(.ADDR_W(ADDR_W), .BYTES(BYTES), .LANE_W(LANE_W)) u_array (
      .clk(clk), .we(wr_en), .wmask(wr_mask), .waddr(wr_addr),
      .wdata(dq_in), .raddr(s1_addr), .rdata(rd_data)
   );

   pbsram_pipe #(.ADDR_W(ADDR_W), .BYTES(BYTES), .LANE_W(LANE_W)) u_pipe (
      .clk(clk), .rst_n(rst_n), .en(en), .s1_op(s1_op), .s1_addr(s1_addr),
      .s1_mask(s1_mask), .dq_in(dq_in), .rd_data(rd_data),
      .out_en_n(out_en_n), .sleep(sleep), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_mask(wr_mask), .s2_write(s2_write), .dq_out(dq_out), .dq_oe(dq_oe)
   );
endmodule

// File: rtl/pbsram_chk.sv
module pbsram_chk #(
   parameter int ADDR_W  = 6,
   parameter int DW      = 16,
   parameter int BURST_W = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              adv_ld,
   input logic              out_en_n,
   input logic              clk_en_n,
   input logic              sleep,
   input logic [ADDR_W-1:0] s1_addr,
   input logic              s2_write,
   input logic [DW-1:0]     dq_out,
   input logic              dq_oe
);
   logic past_valid;
   logic step_edge;

   assign step_edge = !clk_en_n && !sleep && adv_ld;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) past_valid <= 1'b0;
      else        past_valid <= 1'b1;
   end

   // R10: sleep releases the bus
   p_sleep_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      sleep |-> !dq_oe);

   // R7: bus is only driven while output enable is active
   p_oe_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
      dq_oe |-> !out_en_n);

   // R8: write data phase never drives
   p_write_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      s2_write |-> !dq_oe);

   // R9: a stalled edge leaves the bus unchanged
   p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (past_valid && $past(clk_en_n) && !$past(sleep) && !sleep && $stable(out_en_n))
      |-> ($stable(dq_oe) && $stable(dq_out)));

   // R4: continue steps the low address bits by one, modulo the burst length
   p_burst_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (past_valid && $past(step_edge))
      |-> (s1_addr[BURST_W-1:0] == BURST_W'($past(s1_addr[BURST_W-1:0]) + BURST_W'(1))));

   // R4: continue keeps the upper address bits
   p_burst_upper_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (past_valid && $past(step_edge))
      |-> ((s1_addr >> BURST_W) == ($past(s1_addr) >> BURST_W)));
endmodule

bind pbsram pbsram_chk #(.ADDR_W(ADDR_W), .DW(BYTES*LANE_W), .BURST_W(BURST_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .adv_ld(adv_ld), .out_en_n(out_en_n),
   .clk_en_n(clk_en_n), .sleep(sleep), .s1_addr(s1_addr),
   .s2_write(s2_write), .dq_out(dq_out), .dq_oe(dq_oe)
);

// File: tb/pbsram_bench.sv
module pbsram_bench;
   localparam int CLK_PERIOD = 10;
   localparam int ADDR_W = 6;
   localparam int BYTES  = 2;
   localparam int LANE_W = 8;
   localparam int DW     = BYTES * LANE_W;
   localparam int DEPTH  = 1 << ADDR_W;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sel0_n = 1'b1, sel1 = 1'b0, sel2_n = 1'b1;
   logic adv_ld = 1'b0, wr_n = 1'b1;
   logic [BYTES-1:0] byte_wr_n = '1;
   logic out_en_n = 1'b0, clk_en_n = 1'b0, sleep = 1'b0;
   logic [ADDR_W-1:0] addr = '0;
   logic [DW-1:0] dq_in = '0;
   logic [DW-1:0] dq_out;
   logic dq_oe;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pbsram #(.ADDR_W(ADDR_W), .BYTES(BYTES), .LANE_W(LANE_W), .BURST_W(2)) u_pbsram (
      .clk(clk), .rst_n(rst_n), .sel0_n(sel0_n), .sel1(sel1), .sel2_n(sel2_n),
      .adv_ld(adv_ld), .wr_n(wr_n), .byte_wr_n(byte_wr_n), .out_en_n(out_en_n),
      .clk_en_n(clk_en_n), .sleep(sleep), .addr(addr), .dq_in(dq_in),
      .dq_out(dq_out), .dq_oe(dq_oe)
   );

   // ---- transaction model built from the requirements ----
   logic [DW-1:0] m_mem [DEPTH];
   int m1_op, m2_op;               // 0 none/deselect, 1 read, 2 write
   logic [ADDR_W-1:0] m1_addr, m2_addr;
   logic [BYTES-1:0]  m1_mask, m2_mask;
   logic exp_drv;
   logic [DW-1:0] exp_dout;

   function automatic logic [ADDR_W-1:0] burst_next(input logic [ADDR_W-1:0] a);
      return (a & ~ADDR_W'(3)) | ((a + ADDR_W'(1)) & ADDR_W'(3));
   endfunction

   function automatic logic [DW-1:0] lane_write(input logic [DW-1:0] old,
         input logic [DW-1:0] d, input logic [BYTES-1:0] m);
      logic [DW-1:0] r = old;
      for (int g = 0; g < BYTES; g++)
         if (m[g]) r[g*LANE_W +: LANE_W] = d[g*LANE_W +: LANE_W];
      return r;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m1_op = 0; m2_op = 0; m1_addr = '0; m2_addr = '0;
         m1_mask = '0; m2_mask = '0; exp_drv = 1'b0; exp_dout = '0;
      end else if (!clk_en_n && !sleep) begin
         if (m2_op == 2) m_mem[m2_addr] = lane_write(m_mem[m2_addr], dq_in, m2_mask);
         if (m1_op == 1) begin exp_dout = m_mem[m1_addr]; exp_drv = 1'b1; end
         else exp_drv = 1'b0;
         m2_op = m1_op; m2_addr = m1_addr; m2_mask = m1_mask;
         if (!adv_ld) begin
            if (!sel0_n && sel1 && !sel2_n) begin
               m1_op = wr_n ? 1 : 2; m1_addr = addr;
            end else m1_op = 0;
         end else m1_addr = burst_next(m1_addr);
         m1_mask = (m1_op == 2) ? ~byte_wr_n : '0;
      end
   end

   task automatic check(input string tag);
      logic eo;
      eo = exp_drv && !out_en_n && !sleep;
      n_chk++;
      if (dq_oe !== eo || (eo && dq_out !== exp_dout)) begin
         n_bad++;
         $display("FAIL %s: dq_oe=%0b dq_out=%h expected dq_oe=%0b dq_out=%h",
                  tag, dq_oe, dq_out, eo, exp_dout);
      end
   endtask

   task automatic step(input string tag, input logic s0n, input logic s1v,
         input logic s2n, input logic av, input logic wv,
         input logic [BYTES-1:0] bw, input logic [ADDR_W-1:0] a);
      sel0_n = s0n; sel1 = s1v; sel2_n = s2n; adv_ld = av; wr_n = wv;
      byte_wr_n = bw; addr = a; dq_in = DW'($urandom);
      @(negedge clk);
      check(tag);
   endtask

   task automatic rd(input string tag, input logic [ADDR_W-1:0] a);
      step(tag, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, '1, a);
   endtask
   task automatic wr(input string tag, input logic [ADDR_W-1:0] a, input logic [BYTES-1:0] bw);
      step(tag, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, bw, a);
   endtask
   task automatic cont(input string tag, input logic [BYTES-1:0] bw);
      step(tag, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, bw, ADDR_W'($urandom));
   endtask
   task automatic nop(input string tag);
      step(tag, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, '1, '0);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not end, actual=hung expected=finished");
      finish_run();
   end

   initial begin
      void'($urandom(32'h0001_5eed));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      n_chk++;
      if (dq_oe !== 1'b0) begin
         n_bad++; $display("FAIL R1: dq_oe=%0b expected 0", dq_oe);
      end
      cont("R1", '0); cont("R1", '0); cont("R1", '1); nop("R1"); nop("R1");

      // fill memory with full-mask bursts (R3, R4)
      for (int a = 0; a < DEPTH; a += 4) begin
         wr("R3", ADDR_W'(a), '0);
         for (int k = 0; k < 3; k++) cont("R4", '0);
      end
      nop("R3"); nop("R3");

      rd("R2", 6'd5); nop("R2"); nop("R2");
      rd("R4", 6'd7); cont("R4", '1); cont("R4", '1); cont("R4", '1); nop("R4"); nop("R4");
      rd("R4", 6'd63); cont("R4", '1); cont("R4", '1); cont("R4", '1); nop("R4"); nop("R4");

      wr("R11", 6'd9, 2'b00); rd("R11", 6'd9); nop("R11");
      wr("R11", 6'd10, 2'b10); rd("R11", 6'd10); nop("R11");
      wr("R3", 6'd20, 2'b01); nop("R3"); nop("R3"); rd("R3", 6'd20); nop("R3"); nop("R3");

      wr("R5", 6'd12, 2'b11); cont("R5", 2'b11); cont("R5", 2'b11); nop("R5"); nop("R5");
      rd("R5", 6'd12); cont("R5", '1); cont("R5", '1); nop("R5"); nop("R5");

      step("R6", 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, '1, 6'd1);
      step("R6", 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, '1, 6'd2);
      step("R6", 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, '0, 6'd3);
      cont("R6", '0); cont("R6", '0); nop("R6"); nop("R6");

      out_en_n = 1'b1; rd("R7", 6'd33); nop("R7"); nop("R7");
      out_en_n = 1'b0; nop("R7");

      rd("R8", 6'd40); wr("R8", 6'd41, 2'b00); rd("R8", 6'd41);
      wr("R8", 6'd40, 2'b01); rd("R8", 6'd40); nop("R8"); nop("R8");

      rd("R9", 6'd44); nop("R9");
      clk_en_n = 1'b1; nop("R9"); nop("R9"); nop("R9");
      clk_en_n = 1'b0; nop("R9"); nop("R9");
      wr("R9", 6'd45, 2'b00); nop("R9");
      clk_en_n = 1'b1; nop("R9"); nop("R9");
      clk_en_n = 1'b0; nop("R9"); rd("R9", 6'd45); nop("R9"); nop("R9");

      rd("R10", 6'd50); cont("R10", '1);
      sleep = 1'b1; nop("R10"); nop("R10");
      sleep = 1'b0; nop("R10"); nop("R10"); nop("R10");

      // constrained random mix
      for (int i = 0; i < 4000; i++) begin
         int kind = int'($urandom_range(0, 9));
         out_en_n = ($urandom_range(0, 7) == 0);
         clk_en_n = ($urandom_range(0, 15) == 0);
         sleep    = ($urandom_range(0, 31) == 0);
         case (kind)
            0, 1:    rd("R2", ADDR_W'($urandom));
            2, 3:    wr("R3", ADDR_W'($urandom), BYTES'($urandom));
            4, 5, 6: cont("R4", BYTES'($urandom));
            7:       wr("R5", ADDR_W'($urandom), '1);
            8:       step("R6", 1'($urandom), 1'($urandom), 1'b1, 1'b0,
                          1'($urandom), BYTES'($urandom), ADDR_W'($urandom));
            default: nop("R6");
         endcase
      end
      out_en_n = 1'b0; clk_en_n = 1'b0; sleep = 1'b0;
      nop("R2"); nop("R2");
      finish_run();
   end
endmodule